// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA

This engine moves an incoming byte stream into memory. The stream uses a valid/ready handshake and carries an end-of-packet marker. The destination is a chain of buffer descriptors in memory. A start pulse gives the address of the first descriptor. The engine then works through four steps:

- It reads the four descriptor words.
- It writes the bytes it accepts into that buffer, one byte per memory write.
- It closes the descriptor, either when the buffer fills or when a packet ends.
- It writes the descriptor's control word and end-address word back to memory, so software can see how far the buffer was filled and whether a packet boundary fell inside it.

When a descriptor closes, the engine can raise one-cycle interrupt-set pulses. Bits 0 and 1 are raised when the descriptor asks for a completion interrupt. Bit 3 is raised when the close came from a packet end. After the write-back the engine either follows the chain to the next descriptor or, at end of list, halts and signals that the context is disabled. The memory master port is a plain request/grant port with a separate read-valid return. Only one request is outstanding at a time.

Top module: `sg_rx_dma`

## Requirements
- R1: A descriptor is four 32-bit words at byte offsets 0 (next descriptor), 4 (buffer start), 8 (control: bit 0 end of list, bit 4 interrupt on close, bit 11 input end-of-packet) and 12 (end address, exclusive). A start pulse fetches the descriptor at the given address.
- R2: Accepted bytes are written in arrival order to successive byte addresses, beginning at the buffer start. Each is a 32-bit write with the byte replicated on all lanes and a one-hot byte enable selected by address bits [1:0]. No byte is written at or beyond the end address.
- R3: A descriptor closes when its pointer reaches the end address or when a byte marked last is accepted, whichever happens first. A descriptor whose buffer start equals its end address closes at once and takes no byte.
- R4: On close, word 12 of the descriptor is rewritten with the final buffer pointer.
- R5: On close, word 8 is rewritten with bit 11 set exactly when the close was caused by end of packet. All other control bits keep their fetched values.
- R6: A close of a descriptor whose bit 4 is set gives a one-cycle pulse on interrupt-set bits 0 and 1.
- R7: A close caused by end of packet gives a one-cycle pulse on interrupt-set bit 3.
- R8: A close with neither condition gives no interrupt-set pulse. Bit 2 is never pulsed.
- R9: Without end of list, the engine fetches the descriptor at the next pointer after write-back and continues there. A packet may span descriptors.
- R10: With end of list, after write-back the halted output rises together with a one-cycle context-disable pulse. Ready then stays low and no byte is accepted until the next start.
- R11: Ready is low while descriptors are fetched or written back. Under any grant stall, every accepted byte is written exactly once.
- R12: After reset, ready, memory request, interrupt-set, halted and context-disable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin processing a chain (accepted when idle or halted) |
| first_desc_i | input | AW | Byte address of the first descriptor |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Byte is the last of its packet |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_gnt_i | input | 1 | Request taken this cycle |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Read data |
| intr_set_o | output | 4 | One-cycle interrupt-set pulses on close |
| halted_o | output | 1 | End of list reached |
| ctx_dis_o | output | 1 | One-cycle context-disable pulse |

## Verification
The engine is driven with several input patterns, each separating one pair of behaviours:

- **Packet longer than the first buffer.** This separates a fill close from a packet-end close. Bytes must continue in the next descriptor of the chain.
- **Short packet into a large buffer.** This shows the early close and the rewritten end address.
- **Packet whose last byte exactly fills the buffer.** Both close causes hold at once, and the end-of-packet flag and bit 3 must still appear.
- **Zero-length descriptor.** This shows that a close takes place with no byte accepted.
- **Bytes offered after end of list.** These show that the halted state takes nothing.
- **Random grant stalls on one run.** These separate a correct handshake from one that drops or duplicates bytes.

// File: rtl/sg_rx_pkg.sv
package sg_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FWAIT,
    ST_RECV,
    ST_WBC,
    ST_WBE,
    ST_STOP
  } st_e;

  // word indices inside a descriptor
  localparam logic [1:0] W_NEXT = 2'd0;
  localparam logic [1:0] W_BUF  = 2'd1;
  localparam logic [1:0] W_CTRL = 2'd2;
  localparam logic [1:0] W_END  = 2'd3;

  // control word bit positions
  localparam int CB_EOL  = 0;
  localparam int CB_INTR = 4;
  localparam int CB_IEOP = 11;

endpackage

// File: rtl/sg_rx_desc.sv
module sg_rx_desc (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_i,
  input  logic [1:0]  idx_i,
  input  logic [31:0] word_i,
  output logic [31:0] next_o,
  output logic [31:0] buf_o,
  output logic [31:0] ctrl_o,
  output logic [31:0] end_o
);
  import sg_rx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_o <= '0;
      buf_o  <= '0;
      ctrl_o <= '0;
      end_o  <= '0;
    end else if (cap_i) begin
      case (idx_i)
        W_NEXT:  next_o <= word_i;
        W_BUF:   buf_o  <= word_i;
        W_CTRL:  ctrl_o <= word_i;
        default: end_o  <= word_i;
      endcase
    end
  end
endmodule

// File: rtl/sg_rx_irq.sv
module sg_rx_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       close_i,
  input  logic       want_intr_i,
  input  logic       by_eop_i,
  output logic [3:0] set_o
);
  always_ff @(posedge clk) begin
    if (rst)          set_o <= 4'b0000;
    else if (close_i) set_o <= {by_eop_i, 1'b0, want_intr_i, want_intr_i};
    else              set_o <= 4'b0000;
  end
endmodule

// File: rtl/sg_rx_dma.sv
module sg_rx_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] first_desc_i,
  input  logic          s_valid_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [3:0]    intr_set_o,
  output logic          halted_o,
  output logic          ctx_dis_o
);
  import sg_rx_pkg::*;

  localparam logic [AW-1:0] OFS_CTRL = AW'(8);
  localparam logic [AW-1:0] OFS_END  = AW'(12);

  st_e           state;
  logic [AW-1:0] desc_addr;
  logic [AW-1:0] ptr;
  logic [1:0]    widx;
  logic          eop_q;

  logic [31:0]   d_next, d_buf, d_ctrl, d_end;
  logic          cap;
  logic          zero_len;
  logic          accept;
  logic [AW-1:0] ptr_inc;
  logic          close_now;
  logic          close_eop;

  assign cap      = (state == ST_FWAIT) && mem_rvalid_i;
  assign zero_len = (state == ST_RECV) && (ptr == AW'(d_end));
  assign accept   = s_valid_i && s_ready_o;
  assign ptr_inc  = ptr + AW'(1);
  assign close_now = zero_len ||
                     (accept && ((ptr_inc == AW'(d_end)) || s_last_i));
  assign close_eop = !zero_len && accept && s_last_i;

  sg_rx_desc u_desc (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .idx_i  (widx),
    .word_i (mem_rdata_i),
    .next_o (d_next),
    .buf_o  (d_buf),
    .ctrl_o (d_ctrl),
    .end_o  (d_end)
  );

  sg_rx_irq u_irq (
    .clk         (clk),
    .rst         (rst),
    .close_i     (close_now),
    .want_intr_i (d_ctrl[CB_INTR]),
    .by_eop_i    (close_eop),
    .set_o       (intr_set_o)
  );

  // memory and stream side
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = 4'b0000;
    s_ready_o   = 1'b0;
    case (state)
      ST_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + AW'({widx, 2'b00});
      end
      ST_RECV: begin
        if (!zero_len) begin
          mem_req_o   = s_valid_i;
          mem_we_o    = 1'b1;
          mem_addr_o  = ptr;
          mem_wdata_o = {4{s_data_i}};
          mem_be_o    = 4'b0001 << ptr[1:0];
          s_ready_o   = mem_gnt_i;
        end
      end
      ST_WBC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + OFS_CTRL;
        mem_wdata_o = d_ctrl;
        mem_wdata_o[CB_IEOP] = eop_q;
        mem_be_o    = 4'b1111;
      end
      ST_WBE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + OFS_END;
        mem_wdata_o = 32'(ptr);
        mem_be_o    = 4'b1111;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      desc_addr <= '0;
      ptr       <= '0;
      widx      <= 2'd0;
      eop_q     <= 1'b0;
      halted_o  <= 1'b0;
      ctx_dis_o <= 1'b0;
    end else begin
      ctx_dis_o <= 1'b0;
      case (state)
        ST_IDLE, ST_STOP: begin
          if (start_i) begin
            desc_addr <= first_desc_i;
            widx      <= 2'd0;
            halted_o  <= 1'b0;
            state     <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_gnt_i) state <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rvalid_i) begin
            if (widx == W_END) begin
              ptr   <= AW'(d_buf);
              state <= ST_RECV;
            end else begin
              widx  <= widx + 2'd1;
              state <= ST_FREQ;
            end
          end
        end
        ST_RECV: begin
          if (accept) ptr <= ptr_inc;
          if (close_now) begin
            eop_q <= close_eop;
            state <= ST_WBC;
          end
        end
        ST_WBC: if (mem_gnt_i) state <= ST_WBE;
        ST_WBE: begin
          if (mem_gnt_i) begin
            if (d_ctrl[CB_EOL]) begin
              halted_o  <= 1'b1;
              ctx_dis_o <= 1'b1;
              state     <= ST_STOP;
            end else begin
              desc_addr <= AW'(d_next);
              widx      <= 2'd0;
              state     <= ST_FREQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_rx_dma_chk.sv
module sg_rx_dma_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_be_o,
  input logic [3:0] intr_set_o,
  input logic       halted_o,
  input logic       ctx_dis_o
);
  assert_halt_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !s_ready_o);

  assert_dis_in_halt_R10: assert property (@(posedge clk) disable iff (rst)
    ctx_dis_o |-> halted_o);

  assert_dis_single_R10: assert property (@(posedge clk) disable iff (rst)
    ctx_dis_o |=> !ctx_dis_o);

  assert_byte_written_R11: assert property (@(posedge clk) disable iff (rst)
    (s_valid_i && s_ready_o) |-> (mem_req_o && mem_we_o && $onehot(mem_be_o)));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    (intr_set_o != 4'b0000) |=> (intr_set_o == 4'b0000));

  assert_no_bit2_R8: assert property (@(posedge clk) disable iff (rst)
    !intr_set_o[2]);
endmodule

bind sg_rx_dma sg_rx_dma_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .s_valid_i  (s_valid_i),
  .s_ready_o  (s_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o),
  .intr_set_o (intr_set_o),
  .halted_o   (halted_o),
  .ctx_dis_o  (ctx_dis_o)
);

// File: tb/sg_rx_dma_tb.sv
module sg_rx_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] first_desc_i = '0;
  logic          s_valid_i = 1'b0;
  logic [7:0]    s_data_i = '0;
  logic          s_last_i = 1'b0;
  logic          s_ready_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [3:0]    mem_be_o;
  logic          mem_gnt_i;
  logic          mem_rvalid_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic [3:0]    intr_set_o;
  logic          halted_o, ctx_dis_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];
  logic [7:0]  lfsr = 8'hA5;
  logic        stall_en = 1'b0;
  logic [3:0]  raw_acc;
  int          pulse_cnt;
  int          dis_cnt;
  logic        acc_clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_gnt_i = stall_en ? lfsr[0] : 1'b1;

  sg_rx_dma #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .first_desc_i(first_desc_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .intr_set_o(intr_set_o),
    .halted_o(halted_o), .ctx_dis_o(ctx_dis_o)
  );

  // memory model, grant generator and interrupt collector
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rvalid_i <= mem_req_o && mem_gnt_i && !mem_we_o;
    if (mem_req_o && mem_gnt_i && !mem_we_o)
      mem_rdata_i <= mem[mem_addr_o[11:2]];
    if (mem_req_o && mem_gnt_i && mem_we_o) begin
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[11:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    end
    if (rst || acc_clr) begin
      raw_acc <= 4'b0; pulse_cnt <= 0; dis_cnt <= 0;
    end else begin
      raw_acc <= raw_acc | intr_set_o;
      if (intr_set_o != 4'b0) pulse_cnt <= pulse_cnt + 1;
      if (ctx_dis_o) dis_cnt <= dis_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic put_desc(input int a, input int nxt, input int bufp,
                          input int ctrl, input int endp);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = bufp;
    mem[a/4 + 2] = ctrl;
    mem[a/4 + 3] = endp;
  endtask

  task automatic clr_acc();
    @(negedge clk); acc_clr = 1'b1;
    @(negedge clk); acc_clr = 1'b0;
  endtask

  task automatic kick(input int a);
    @(negedge clk); start_i = 1'b1; first_desc_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] base, input bit last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid_i = 1'b1;
      s_data_i  = base + 8'(i);
      s_last_i  = last && (i == n - 1);
      #1;
      while (!s_ready_o) begin
        @(negedge clk); #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic wait_halt();
    for (int k = 0; k < 2000 && !halted_o; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12 ready", {31'b0, s_ready_o}, 0);
    chk("R12 req", {31'b0, mem_req_o}, 0);
    chk("R12 intr", {28'b0, intr_set_o}, 0);
    chk("R12 halted", {31'b0, halted_o}, 0);
    chk("R12 ctxdis", {31'b0, ctx_dis_o}, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  // packet longer than first buffer, chained descriptors
  task automatic t_chain();
    put_desc(32'h100, 32'h140, 32'h400, 32'h0000_0010, 32'h404);
    put_desc(32'h140, 32'h0,   32'h500, 32'h0000_0001, 32'h510);
    clr_acc();
    kick(32'h100);
    send_bytes(6, 8'h30, 1'b1);
    wait_halt();
    for (int i = 0; i < 4; i++) chk("R2 first buffer byte", rd_byte(32'h400 + i), 8'h30 + i);
    chk("R9 spill byte0", rd_byte(32'h500), 8'h34);
    chk("R9 spill byte1", rd_byte(32'h501), 8'h35);
    chk("R2 no write past fill", rd_byte(32'h502), 8'hEE);
    chk("R4 end rewrite d0", mem[32'h10C/4], 32'h404);
    chk("R5 ctrl d0 no eop", mem[32'h108/4], 32'h10);
    chk("R4 end rewrite d1", mem[32'h14C/4], 32'h502);
    chk("R5 ctrl d1 eop", mem[32'h148/4], 32'h801);
    chk("R6 R7 raw bits", {28'b0, raw_acc}, 4'b1011);
    chk("R10 halted", {31'b0, halted_o}, 1);
    chk("R10 ctx disable pulses", dis_cnt, 1);
  endtask

  // bytes offered after end of list
  task automatic t_after_eol();
    int seen = 0;
    @(negedge clk);
    s_valid_i = 1'b1; s_data_i = 8'h99; s_last_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1; if (s_ready_o) seen++;
      @(negedge clk);
    end
    s_valid_i = 1'b0;
    chk("R10 ready low after eol", seen, 0);
    chk("R10 memory untouched", rd_byte(32'h502), 8'hEE);
  endtask

  // zero-length descriptor with interrupt request
  task automatic t_zero_len();
    put_desc(32'h180, 32'h0, 32'h600, 32'h0000_0011, 32'h600);
    clr_acc();
    kick(32'h180);
    wait_halt();
    chk("R3 zero-len end", mem[32'h18C/4], 32'h600);
    chk("R5 zero-len ctrl", mem[32'h188/4], 32'h11);
    chk("R6 zero-len bits", {28'b0, raw_acc}, 4'b0011);
    chk("R3 zero-len no byte", rd_byte(32'h600), 8'hEE);
    chk("R10 halted again", {31'b0, halted_o}, 1);
  endtask

  // short packet under grant stalls
  task automatic t_short_stall();
    put_desc(32'h1C0, 32'h0, 32'h701, 32'h0000_0001, 32'h709);
    clr_acc();
    stall_en = 1'b1;
    kick(32'h1C0);
    send_bytes(3, 8'hA0, 1'b1);
    wait_halt();
    stall_en = 1'b0;
    for (int i = 0; i < 3; i++) chk("R11 stalled byte", rd_byte(32'h701 + i), 8'hA0 + i);
    chk("R3 early close stop", rd_byte(32'h704), 8'hEE);
    chk("R4 short end", mem[32'h1CC/4], 32'h704);
    chk("R5 short ctrl", mem[32'h1C8/4], 32'h801);
    chk("R7 only bit3", {28'b0, raw_acc}, 4'b1000);
  endtask

  // quiet close then exact fill with eop
  task automatic t_exact_fill();
    put_desc(32'h200, 32'h240, 32'h800, 32'h0000_0000, 32'h802);
    put_desc(32'h240, 32'h0,   32'h880, 32'h0000_0001, 32'h884);
    clr_acc();
    kick(32'h200);
    send_bytes(6, 8'h50, 1'b1);
    wait_halt();
    chk("R8 quiet close ctrl", mem[32'h208/4], 32'h0);
    chk("R8 one pulse only", pulse_cnt, 1);
    chk("R7 exact fill bits", {28'b0, raw_acc}, 4'b1000);
    chk("R5 exact fill ctrl", mem[32'h248/4], 32'h801);
    chk("R4 exact fill end", mem[32'h24C/4], 32'h884);
    chk("R1 R9 last byte", rd_byte(32'h883), 8'h55);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    t_reset();
    t_chain();
    t_after_eol();
    t_zero_len();
    t_short_stall();
    t_exact_fill();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule